// File: doc/BRIEF.md
# Two-Pattern Launch/Capture Delay Test Sequencer

This block runs a two-pattern timing test on a combinational circuit under test. A register inside the block drives the circuit's inputs, and a second register samples the circuit's outputs. For each test pair the block first drives an initialising pattern. It then waits a long, programmable settle interval so that every node in the circuit reaches a steady value. Next it drives the launching pattern, and it samples the outputs exactly a programmable rated interval later. If a slow path has not yet delivered its new value at that moment, the sampled word differs from the fault-free word, and the pair is reported as a detected delay fault.

Both intervals are counted in cycles of a single fast reference clock. The input-register strobe and the output-register strobe are separate pulses, so the gap between launch and capture is independent of the pattern rate. Test pairs arrive on a valid/ready stream together with their expected response. Each finished pair produces a one-cycle result beat. The beat carries a pass/fail flag, the captured word and a running count of failing pairs. A synchronous input clears that count.

Top module: `launch_capture_seq`

## Requirements
- R1: `pair_ready` is high only while the sequencer is idle and the configuration is legal. An accepted pair (valid and ready at a clock edge) raises `launch_strobe` in the following cycle, and `pair_ready` stays low from then until the result beat.
- R2: At the first launch strobe `cut_drive` takes the initialising pattern. At the second launch strobe it takes the launching pattern. Each value appears after the edge that ends the strobe cycle.
- R3: The second launch strobe comes exactly `settle` cycles after the first, where `settle` is the settle count accepted with the pair.
- R4: The capture strobe comes exactly `rated` cycles after the second launch strobe. `res_captured` equals `cut_sample` as it stood in the capture strobe cycle.
- R5: Exactly two cycles after the capture strobe, `res_valid` is high for one cycle. In that cycle `res_fail` is 1 if the captured word differs from `pair_expect` in any bit, and 0 otherwise.
- R6: `res_fail_count` rises by one for each failing pair and is unchanged by a passing pair. Its new value is visible in the result beat.
- R7: A high `clr_fail_cnt` at a clock edge makes `res_fail_count` zero after that edge. Clearing wins over a count in the same cycle.
- R8: `cfg_error` is high when the rated count is zero or is not smaller than the settle count. While it is high no pair is accepted and no strobe is issued.
- R9: The settle and rated counts are captured when a pair is accepted. Changing them during a test has no effect on that test's strobe spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| clr_fail_cnt | input | 1 | Synchronous clear of the failing-pair count |
| cfg_settle_cycles | input | CW | Settle interval in reference cycles |
| cfg_rated_cycles | input | CW | Rated launch-to-capture interval in reference cycles |
| cfg_error | output | 1 | Current configuration is illegal |
| pair_valid | input | 1 | Test pair offered |
| pair_ready | output | 1 | Sequencer will take the pair at this edge |
| pair_init | input | PW | Initialising pattern |
| pair_launch | input | PW | Launching pattern |
| pair_expect | input | OW | Fault-free response to the launching pattern |
| cut_drive | output | PW | Input register feeding the circuit under test |
| launch_strobe | output | 1 | Input register loads at the end of this cycle |
| capture_strobe | output | 1 | Output register samples at the end of this cycle |
| cut_sample | input | OW | Combinational output of the circuit under test |
| res_valid | output | 1 | Result beat |
| res_fail | output | 1 | Pair detected a delay fault |
| res_captured | output | OW | Word sampled at capture |
| res_fail_count | output | FCW | Running count of failing pairs |

## Verification
Assertions check the following on every cycle:
- The launch strobe follows acceptance.
- The gaps between strobes equal the latched settle and rated counts. A free-running gap counter measures them.
- The result beat is a single cycle, two cycles after capture.
- The count steps by exactly the fail flag, and clear forces zero.
- A configuration error blocks acceptance.

Some behaviour only the bench scenarios can show. The bench models a circuit whose path delay can be dialled relative to the rated count. Its scenarios show that the driven pattern values are correct and that a slow path really turns into a reported fault while a fast path passes. They also show the exact boundary at delay equal to the rated count, and that configuration changes after acceptance are ignored.

// File: rtl/lcs_pkg.sv
`timescale 1ns/1ps
package lcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LOAD_P1  = 3'd1,
    ST_SETTLE   = 3'd2,
    ST_LOAD_P2  = 3'd3,
    ST_WAIT_CAP = 3'd4,
    ST_COMPARE  = 3'd5,
    ST_REPORT   = 3'd6
  } lcs_state_e;

endpackage

// File: rtl/lcs_timer.sv
`timescale 1ns/1ps
module lcs_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign done = (cnt_q == CW'(1));

  // R3
  timer_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/lcs_ctrl.sv
`timescale 1ns/1ps
module lcs_ctrl
  import lcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic timer_done,
  output logic idle,
  output logic launch_p1,
  output logic launch_p2,
  output logic capture,
  output logic compare,
  output logic report,
  output logic tmr_load,
  output logic tmr_sel_rated
);

  lcs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (accept) state_d = ST_LOAD_P1;
      ST_LOAD_P1:  state_d = ST_SETTLE;
      ST_SETTLE:   if (timer_done) state_d = ST_LOAD_P2;
      ST_LOAD_P2:  state_d = ST_WAIT_CAP;
      ST_WAIT_CAP: if (timer_done) state_d = ST_COMPARE;
      ST_COMPARE:  state_d = ST_REPORT;
      ST_REPORT:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle          = (state_q == ST_IDLE);
  assign launch_p1     = (state_q == ST_LOAD_P1);
  assign launch_p2     = (state_q == ST_LOAD_P2);
  assign capture       = (state_q == ST_WAIT_CAP) && timer_done;
  assign compare       = (state_q == ST_COMPARE);
  assign report        = (state_q == ST_REPORT);
  assign tmr_load      = launch_p1 || launch_p2;
  assign tmr_sel_rated = launch_p2;

  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {ST_IDLE, ST_LOAD_P1, ST_SETTLE, ST_LOAD_P2,
                    ST_WAIT_CAP, ST_COMPARE, ST_REPORT});

  // R5
  compare_to_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compare |=> report);

endmodule

// File: rtl/lcs_result.sv
`timescale 1ns/1ps
module lcs_result #(
  parameter int OW  = 8,
  parameter int FCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [OW-1:0]  sample,
  input  logic           compare,
  input  logic [OW-1:0]  expect_word,
  input  logic           clr,
  output logic [OW-1:0]  cap_q,
  output logic           fail_q,
  output logic [FCW-1:0] cnt_q
);

  function automatic logic word_differs(input logic [OW-1:0] a, input logic [OW-1:0] b);
    return |(a ^ b);
  endfunction

  logic mism;
  assign mism = word_differs(cap_q, expect_word);

  always_ff @(posedge clk) begin
    if (!rst_n)       cap_q <= '0;
    else if (capture) cap_q <= sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (compare) fail_q <= mism;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (compare && mism)  cnt_q <= cnt_q + FCW'(1);
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R6
  idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!compare && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/launch_capture_seq.sv
`timescale 1ns/1ps
module launch_capture_seq #(
  parameter int PW  = 8,
  parameter int OW  = 8,
  parameter int CW  = 16,
  parameter int FCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_fail_cnt,
  input  logic [CW-1:0]  cfg_settle_cycles,
  input  logic [CW-1:0]  cfg_rated_cycles,
  output logic           cfg_error,
  input  logic           pair_valid,
  output logic           pair_ready,
  input  logic [PW-1:0]  pair_init,
  input  logic [PW-1:0]  pair_launch,
  input  logic [OW-1:0]  pair_expect,
  output logic [PW-1:0]  cut_drive,
  output logic           launch_strobe,
  output logic           capture_strobe,
  input  logic [OW-1:0]  cut_sample,
  output logic           res_valid,
  output logic           res_fail,
  output logic [OW-1:0]  res_captured,
  output logic [FCW-1:0] res_fail_count
);

  localparam int GW = CW + 1;

  function automatic logic timing_illegal(input logic [CW-1:0] settle, input logic [CW-1:0] rated);
    return (rated == '0) || (rated >= settle);
  endfunction

  function automatic logic [CW-1:0] settle_preload(input logic [CW-1:0] settle);
    return settle - CW'(1);
  endfunction

  logic idle_w, launch_p1_w, launch_p2_w, capture_w, compare_w, report_w;
  logic tmr_load_w, tmr_sel_w, tmr_done_w, accept_w;

  logic [PW-1:0] p1_q, p2_q;
  logic [OW-1:0] exp_q;
  logic [CW-1:0] settle_q, rated_q, tmr_val_w;

  assign cfg_error  = timing_illegal(cfg_settle_cycles, cfg_rated_cycles);
  assign pair_ready = idle_w && !cfg_error;
  assign accept_w   = pair_valid && pair_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_q     <= '0;
      p2_q     <= '0;
      exp_q    <= '0;
      settle_q <= CW'(2);
      rated_q  <= CW'(1);
    end else if (accept_w) begin
      p1_q     <= pair_init;
      p2_q     <= pair_launch;
      exp_q    <= pair_expect;
      settle_q <= cfg_settle_cycles;
      rated_q  <= cfg_rated_cycles;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           cut_drive <= '0;
    else if (launch_p1_w) cut_drive <= p1_q;
    else if (launch_p2_w) cut_drive <= p2_q;
  end

  assign tmr_val_w = tmr_sel_w ? rated_q : settle_preload(settle_q);

  lcs_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept_w),
    .timer_done    (tmr_done_w),
    .idle          (idle_w),
    .launch_p1     (launch_p1_w),
    .launch_p2     (launch_p2_w),
    .capture       (capture_w),
    .compare       (compare_w),
    .report        (report_w),
    .tmr_load      (tmr_load_w),
    .tmr_sel_rated (tmr_sel_w)
  );

  lcs_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load_w),
    .load_val (tmr_val_w),
    .done     (tmr_done_w)
  );

  lcs_result #(.OW(OW), .FCW(FCW)) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (capture_w),
    .sample      (cut_sample),
    .compare     (compare_w),
    .expect_word (exp_q),
    .clr         (clr_fail_cnt),
    .cap_q       (res_captured),
    .fail_q      (res_fail),
    .cnt_q       (res_fail_count)
  );

  assign launch_strobe  = launch_p1_w || launch_p2_w;
  assign capture_strobe = capture_w;
  assign res_valid      = report_w;

  // Gap counter: cycles since the last strobe, saturating.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                              gap_q <= '0;
    else if (launch_strobe || capture_strobe) gap_q <= GW'(1);
    else if (gap_q != '1)                    gap_q <= gap_q + GW'(1);
  end

  // R1
  accept_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> launch_strobe);

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_strobe || capture_strobe) |-> !pair_ready);

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_p2_w |-> (gap_q == {1'b0, settle_q}));

  // R4
  rated_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_strobe |-> (gap_q == {1'b0, rated_q}));

  // R5
  capture_to_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_strobe |=> compare_w);

  // R5
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_strobe, capture_strobe, res_valid}));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(clr_fail_cnt)) |->
      (res_fail_count == $past(res_fail_count) + FCW'(res_fail)));

  // R8
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !pair_ready);

endmodule

// File: tb/launch_capture_seq_tb.sv
`timescale 1ns/1ps
module launch_capture_seq_tb_top;

  localparam int PW = 8, OW = 8, CW = 16, FCW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n = 1'b0, clr_fail_cnt = 1'b0;
  logic [CW-1:0]  cfg_settle_cycles = 16'd20, cfg_rated_cycles = 16'd5;
  logic           cfg_error, pair_valid = 1'b0, pair_ready;
  logic [PW-1:0]  pair_init = '0, pair_launch = '0, cut_drive;
  logic [OW-1:0]  pair_expect = '0, cut_sample, res_captured;
  logic           launch_strobe, capture_strobe, res_valid, res_fail;
  logic [FCW-1:0] res_fail_count;

  launch_capture_seq #(.PW(PW), .OW(OW), .CW(CW), .FCW(FCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_fail_cnt(clr_fail_cnt),
    .cfg_settle_cycles(cfg_settle_cycles), .cfg_rated_cycles(cfg_rated_cycles),
    .cfg_error(cfg_error), .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_init(pair_init), .pair_launch(pair_launch), .pair_expect(pair_expect),
    .cut_drive(cut_drive), .launch_strobe(launch_strobe),
    .capture_strobe(capture_strobe), .cut_sample(cut_sample),
    .res_valid(res_valid), .res_fail(res_fail), .res_captured(res_captured),
    .res_fail_count(res_fail_count)
  );

  // Circuit-under-test model with a selectable path delay in cycles.
  function automatic logic [7:0] cut_fn(input logic [7:0] x);
    return x ^ {x[0], x[7:1]} ^ 8'h5A;
  endfunction

  logic [PW-1:0] dl [8];
  int path_dly = 0;
  always_ff @(posedge clk) begin
    dl[0] <= cut_drive;
    for (int i = 1; i < 8; i++) dl[i] <= dl[i-1];
  end
  always_comb begin
    if (path_dly == 0) cut_sample = cut_fn(cut_drive);
    else               cut_sample = cut_fn(dl[path_dly-1]);
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [PW-1:0] p1, p2;
    int settle, rated;
    logic fail;
    logic [OW-1:0] cap;
    int cnt;
    bit scr;
  } exp_t;
  exp_t sb_q[$];
  int model_cnt = 0, results = 0, total_launch = 0;

  // Monitor
  int cyc = 0, nl = 0, l1c = 0, l2c = 0, capc = 0;
  bit grab = 0;
  logic [PW-1:0] got_p1, got_p2;
  always @(negedge clk) begin
    cyc++;
    if (grab) begin
      if (nl == 1) got_p1 = cut_drive; else got_p2 = cut_drive;
      grab = 0;
    end
    if (rst_n && launch_strobe) begin
      nl++; total_launch++;
      if (nl == 1) l1c = cyc; else l2c = cyc;
      grab = 1;
    end
    if (rst_n && capture_strobe) capc = cyc;
    if (rst_n && res_valid) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        chk(0, "R5", "unexpected result beat", 1, 0);
      end else begin
        e = sb_q.pop_front();
        chk(got_p1 == e.p1, "R2", "first pattern driven", int'(got_p1), int'(e.p1));
        chk(got_p2 == e.p2, "R2", "second pattern driven", int'(got_p2), int'(e.p2));
        chk(l2c - l1c == e.settle, e.scr ? "R9" : "R3", "settle gap", l2c - l1c, e.settle);
        chk(capc - l2c == e.rated, e.scr ? "R9" : "R4", "rated gap", capc - l2c, e.rated);
        chk(cyc - capc == 2, "R5", "beat delay after capture", cyc - capc, 2);
        chk(res_captured == e.cap, "R4", "captured word", int'(res_captured), int'(e.cap));
        chk(res_fail == e.fail, "R5", "fail flag", int'(res_fail), int'(e.fail));
        chk(int'(res_fail_count) == e.cnt, "R6", "fail count", int'(res_fail_count), e.cnt);
      end
      nl = 0;
      results++;
    end
  end

  // Driver: call at a negedge.
  task automatic run_pair(input logic [PW-1:0] p1, input logic [PW-1:0] p2,
                          input int d, input int s, input int r, input bit scramble);
    exp_t e;
    int tgt;
    cfg_settle_cycles = CW'(s);
    cfg_rated_cycles  = CW'(r);
    path_dly = d;
    e.p1 = p1; e.p2 = p2; e.settle = s; e.rated = r; e.scr = scramble;
    e.cap  = (d < r) ? cut_fn(p2) : cut_fn(p1);
    e.fail = (e.cap != cut_fn(p2));
    if (e.fail) model_cnt = (model_cnt + 1) % 256;
    e.cnt = model_cnt;
    sb_q.push_back(e);
    tgt = results + 1;
    pair_init = p1; pair_launch = p2; pair_expect = cut_fn(p2);
    pair_valid = 1'b1;
    #0.1;
    while (!pair_ready) @(negedge clk);
    @(negedge clk);
    pair_valid = 1'b0;
    chk(pair_ready == 1'b0, "R1", "ready low while busy", int'(pair_ready), 0);
    chk(launch_strobe == 1'b1, "R1", "launch follows accept", int'(launch_strobe), 1);
    if (scramble) begin
      cfg_settle_cycles = CW'(s + 9);
      cfg_rated_cycles  = CW'(r + 3);
    end
    while (results < tgt) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 act=timeout exp=finished");
    summary();
    $finish;
  end

  initial begin
    int lsnap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(res_valid == 0, "R5", "reset res_valid", int'(res_valid), 0);
    chk(res_fail_count == 0, "R6", "reset count", int'(res_fail_count), 0);
    chk(launch_strobe == 0 && capture_strobe == 0, "R1", "reset strobes", int'(launch_strobe), 0);
    chk(pair_ready == 1, "R1", "reset ready", int'(pair_ready), 1);

    // Passing and failing pairs around the rated boundary
    run_pair(8'h00, 8'hFF, 0, 20, 5, 0);
    run_pair(8'h3C, 8'hA5, 4, 20, 5, 0);   // d = rated-1 -> pass
    run_pair(8'h3C, 8'hA5, 5, 20, 5, 0);   // d = rated -> fail
    run_pair(8'h12, 8'h81, 7, 30, 3, 0);   // slow path -> fail
    run_pair(8'h55, 8'h55, 7, 30, 3, 0);   // no transition -> pass

    // Minimum legal configuration
    run_pair(8'h01, 8'h80, 0, 2, 1, 0);
    run_pair(8'h01, 8'h80, 1, 2, 1, 0);

    // R9: config changed after acceptance
    run_pair(8'hC3, 8'h3C, 2, 12, 4, 1);

    // R7: clear
    clr_fail_cnt = 1'b1;
    @(negedge clk);
    clr_fail_cnt = 1'b0;
    chk(res_fail_count == 0, "R7", "count after clear", int'(res_fail_count), 0);
    model_cnt = 0;
    run_pair(8'hF0, 8'h0F, 6, 15, 6, 0);

    // R8: illegal configurations
    cfg_settle_cycles = 16'd10; cfg_rated_cycles = 16'd10;
    #0.1;
    chk(cfg_error == 1, "R8", "rated equal settle flags error", int'(cfg_error), 1);
    chk(pair_ready == 0, "R8", "ready low on error", int'(pair_ready), 0);
    cfg_rated_cycles = 16'd0;
    #0.1;
    chk(cfg_error == 1, "R8", "zero rated flags error", int'(cfg_error), 1);
    lsnap = total_launch;
    pair_valid = 1'b1;
    repeat (6) @(negedge clk);
    pair_valid = 1'b0;
    chk(total_launch == lsnap, "R8", "no launch under error", total_launch, lsnap);
    cfg_rated_cycles = 16'd9;
    #0.1;
    chk(cfg_error == 0, "R8", "rated one below settle legal", int'(cfg_error), 0);
    @(negedge clk);
    run_pair(8'h99, 8'h66, 8 - 1, 10, 9, 0);

    summary();
    $finish;
  end

endmodule